// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Controller

This block is the digital sequencer for a supply output that protects itself from a sustained overload by cycling the output: a long shutdown followed by a short, current-limited restart attempt, repeated until the load behaves. An external comparator reports when the output current exceeds the selected threshold. The controller demands that this report hold for a qualification interval, then turns the output off, raises a sticky overload flag and runs a timer. When the off interval ends it switches the output back on with the analog limiter forced to its fixed retry limit. Only a retry window that ends with no overload seen restores normal operation and clears the flag.

A mode input selects static limiting, in which the controller never starts the off/on cycle and leaves limiting to the analog circuit. Two threshold-select inputs are forwarded unchanged as a 2-bit code to the analog limiter. All timing counts ticks of a prescaler driven by the system clock, so qualification, off and on intervals are all parameters in ticks. Removing the chip enable returns everything to an idle, output-off state.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While `chip_en_i` is low or reset is held, `out_en_o`, `retry_lim_o` and `ovl_flag_o` are 0; one clock after `chip_en_i` rises, `out_en_o` is 1 with the other two still 0.
- R2: `thr_code_o` always equals `{thr_hi_i, thr_lo_i}`, bit 1 carrying the high select bit.
- R3: In dynamic mode (`static_lim_i` = 0), an overload held continuously for QUAL_TICKS ticks drives `out_en_o` to 0 and `ovl_flag_o` to 1 on the same edge, between (QUAL_TICKS-1)*PRESCALE+1 and QUAL_TICKS*PRESCALE clocks after it was first sampled.
- R4: An overload that drops before QUAL_TICKS ticks have been seen causes no trip, and the qualification count restarts from zero, so two such short bursts separated by a gap never trip.
- R5: With `static_lim_i` = 1 the controller stays in normal operation whatever `ovl_det_i` does.
- R6: The off interval lasts exactly OFF_TICKS*PRESCALE clocks; it ends with `out_en_o` = 1, `retry_lim_o` = 1 and `ovl_flag_o` still 1.
- R7: The retry window lasts exactly ON_TICKS*PRESCALE clocks; if `ovl_det_i` was high in any clock of it, the controller returns to the off state (`out_en_o` = 0, `retry_lim_o` = 0, `ovl_flag_o` = 1) and repeats the cycle.
- R8: A retry window with no overload ends with `out_en_o` = 1, `retry_lim_o` = 0 and `ovl_flag_o` = 0 on the same edge.
- R9: Dropping `chip_en_i` in any state forces all three outputs to 0 one clock later and clears the timers, so a later enable starts in normal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Block enable; low forces idle |
| static_lim_i | input | 1 | 1 = static limiting, 0 = dynamic hiccup mode |
| thr_hi_i | input | 1 | Threshold select, high bit |
| thr_lo_i | input | 1 | Threshold select, low bit |
| ovl_det_i | input | 1 | Overload comparator output, high = overload |
| thr_code_o | output | 2 | Threshold code to the analog limiter |
| out_en_o | output | 1 | Output stage enable |
| retry_lim_o | output | 1 | Forces the fixed retry current limit |
| ovl_flag_o | output | 1 | Sticky overload flag for the register interface |

## Verification
The bench aims at the qualification boundary: two overload bursts, each just one tick short of the qualification count, separated by a quiet gap; a design that failed to reset its count on a drop would add them and trip. It measures the off and retry windows to the exact clock, which catches off-by-one tick counts, and injects a single-clock overload in the middle of a retry window, which a design that looked only at the last cycle would miss and so wrongly resume. It also drops the enable during the off interval, where a design that kept its flag or timer would show a stale flag or resume out of phase.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_OFF  = 2'd2,
    ST_ON   = 2'd3
  } ocp_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int unsigned PRESCALE = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = ocp_pkg::cnt_width(PRESCALE);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_qualifier.sv
module ocp_qualifier #(
  parameter int unsigned QUAL_TICKS = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ovl_i,
  input  logic tick_i,
  output logic trip_o
);
  localparam int unsigned QW = ocp_pkg::cnt_width(QUAL_TICKS + 1);
  localparam logic [QW-1:0] LAST = QW'(QUAL_TICKS - 1);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign trip_o  = tick_i && ovl_i && !clr_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || !ovl_i)         cnt_d = '0;
    else if (tick_i && !at_last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_window_timer.sv
module ocp_window_timer #(
  parameter int unsigned OFF_TICKS = 900000,
  parameter int unsigned ON_TICKS  = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sel_on_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned MAXT = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int unsigned TW   = ocp_pkg::cnt_width(MAXT);
  localparam logic [TW-1:0] OFF_LAST = TW'(OFF_TICKS - 1);
  localparam logic [TW-1:0] ON_LAST  = TW'(ON_TICKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] limit;

  assign limit  = sel_on_i ? ON_LAST : OFF_LAST;
  assign done_o = tick_i && !clr_i && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || done_o) cnt_d = '0;
    else if (tick_i)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int unsigned PRESCALE   = 200,
  parameter int unsigned QUAL_TICKS = 23,
  parameter int unsigned OFF_TICKS  = 900000,
  parameter int unsigned ON_TICKS   = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_en_i,
  input  logic       static_lim_i,
  input  logic       thr_hi_i,
  input  logic       thr_lo_i,
  input  logic       ovl_det_i,
  output logic [1:0] thr_code_o,
  output logic       out_en_o,
  output logic       retry_lim_o,
  output logic       ovl_flag_o
);
  import ocp_pkg::*;

  ocp_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       seen_q, seen_d;
  logic       tick, trip, win_done;
  logic       qual_clr, win_clr, in_window;

  assign thr_code_o = {thr_hi_i, thr_lo_i};

  assign in_window = (state_q == ST_OFF) || (state_q == ST_ON);
  assign qual_clr  = (state_q != ST_NORM) || static_lim_i || !chip_en_i;
  assign win_clr   = !in_window || !chip_en_i;

  ocp_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (chip_en_i),
    .tick_o (tick)
  );

  ocp_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (qual_clr),
    .ovl_i  (ovl_det_i),
    .tick_i (tick),
    .trip_o (trip)
  );

  ocp_window_timer #(.OFF_TICKS(OFF_TICKS), .ON_TICKS(ON_TICKS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (win_clr),
    .sel_on_i (state_q == ST_ON),
    .tick_i   (tick),
    .done_o   (win_done)
  );

  // Next-state and flag logic
  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    seen_d  = seen_q;
    if (!chip_en_i) begin
      state_d = ST_IDLE;
      flag_d  = 1'b0;
      seen_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_NORM;
        ST_NORM: begin
          if (trip) begin
            state_d = ST_OFF;
            flag_d  = 1'b1;
          end
        end
        ST_OFF: begin
          seen_d = 1'b0;
          if (win_done) state_d = ST_ON;
        end
        ST_ON: begin
          if (ovl_det_i) seen_d = 1'b1;
          if (win_done) begin
            if (seen_q || ovl_det_i) begin
              state_d = ST_OFF;
            end else begin
              state_d = ST_NORM;
              flag_d  = 1'b0;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      seen_q  <= seen_d;
    end
  end

  assign out_en_o    = (state_q == ST_NORM) || (state_q == ST_ON);
  assign retry_lim_o = (state_q == ST_ON);
  assign ovl_flag_o  = flag_q;
endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en_i,
  input logic static_lim_i,
  input logic out_en_o,
  input logic retry_lim_o,
  input logic ovl_flag_o
);
  // R1
  disabled_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |=> (!out_en_o && !retry_lim_o && !ovl_flag_o));

  // R3
  flag_rise_with_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_flag_o) |-> (!out_en_o && $past(out_en_o)));

  // R6
  retry_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_lim_o |-> (out_en_o && ovl_flag_o));

  // R8
  flag_clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl_flag_o) |-> ($past(retry_lim_o) || !out_en_o));

  // R5
  static_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_o && !ovl_flag_o && static_lim_i && chip_en_i) |=> !ovl_flag_o);
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chip_en_i    (chip_en_i),
  .static_lim_i (static_lim_i),
  .out_en_o     (out_en_o),
  .retry_lim_o  (retry_lim_o),
  .ovl_flag_o   (ovl_flag_o)
);

// File: tb/ocp_hiccup_ctrl_tb.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_tb;
  localparam int P = 4;
  localparam int Q = 3;
  localparam int TOFF = 10;
  localparam int TON = 5;
  localparam int BIG = 1000000;

  typedef struct {
    string req;
    bit    oe;
    bit    rl;
    bit    fl;
    int    dmin;
    int    dmax;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, chip_en, static_lim, thr_hi, thr_lo, ovl;
  logic [1:0] thr_code;
  logic out_en, retry_lim, ovl_flag;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    mark = 0;
  bit    fin = 1'b0;
  string phase = "R1";
  item_t exp_q[$];
  logic [2:0] last_t = 3'b000;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ocp_hiccup_ctrl #(.PRESCALE(P), .QUAL_TICKS(Q), .OFF_TICKS(TOFF), .ON_TICKS(TON)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en), .static_lim_i(static_lim),
    .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .ovl_det_i(ovl),
    .thr_code_o(thr_code), .out_en_o(out_en), .retry_lim_o(retry_lim), .ovl_flag_o(ovl_flag)
  );

  task automatic push(string req, bit oe, bit rl, bit fl, int dmin, int dmax);
    item_t it;
    it.req = req; it.oe = oe; it.rl = rl; it.fl = fl; it.dmin = dmin; it.dmax = dmax;
    exp_q.push_back(it);
  endtask

  task automatic direct(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: pops expected output changes and compares tuple and elapsed clocks
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] cur;
      cur = {out_en, retry_lim, ovl_flag};
      if (cur != last_t) begin
        int el;
        el = cyc - mark;
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: unexpected change to oe/rl/fl=%b expected no change", phase, cur);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (cur != {it.oe, it.rl, it.fl} || el < it.dmin || el > it.dmax) begin
            n_bad++;
            $display("FAIL %s: actual oe/rl/fl=%b after %0d clk expected %b after %0d..%0d clk",
                     it.req, cur, el, {it.oe, it.rl, it.fl}, it.dmin, it.dmax);
          end
        end
        last_t = cur;
        mark = cyc;
      end
    end
  end

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_oe(bit v);
    do @(negedge clk); while (out_en != v);
  endtask

  task automatic start_overload();
    @(negedge clk);
    ovl = 1'b1;
    mark = cyc;
  endtask

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; static_lim = 1'b0;
    thr_hi = 1'b0; thr_lo = 1'b0; ovl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset / disabled state
    direct("R1", {out_en, retry_lim, ovl_flag}, 0);

    // R1: enable gives normal operation one clock later
    phase = "R1";
    push("R1", 1, 0, 0, 1, 1);
    mark = cyc;
    chip_en = 1'b1;
    wait_empty();

    // R2: threshold code passthrough
    for (int c = 0; c < 4; c++) begin
      thr_hi = c[1]; thr_lo = c[0];
      #1;
      direct("R2", thr_code, c);
    end

    // R4: two bursts each one tick short of qualification
    phase = "R4";
    @(negedge clk); ovl = 1'b1;
    repeat ((Q - 1) * P) @(negedge clk);
    ovl = 1'b0;
    repeat (3) @(negedge clk);
    ovl = 1'b1;
    repeat ((Q - 1) * P) @(negedge clk);
    ovl = 1'b0;
    repeat (20) @(negedge clk);
    direct("R4", {out_en, ovl_flag}, 2);

    // R5: static mode ignores a long overload
    phase = "R5";
    static_lim = 1'b1;
    @(negedge clk); ovl = 1'b1;
    repeat (Q * P * 5) @(negedge clk);
    direct("R5", {out_en, retry_lim, ovl_flag}, 4);
    ovl = 1'b0;
    @(negedge clk); static_lim = 1'b0;
    repeat (4) @(negedge clk);

    // R3, R6, R7: persistent overload through one retry, then released
    phase = "R3";
    push("R3", 0, 0, 1, (Q - 1) * P + 1, Q * P);
    push("R6", 1, 1, 1, TOFF * P, TOFF * P);
    push("R7", 0, 0, 1, TON * P, TON * P);
    push("R6", 1, 1, 1, TOFF * P, TOFF * P);
    push("R8", 1, 0, 0, TON * P, TON * P);
    start_overload();
    wait_oe(1'b0);
    wait_oe(1'b1);
    wait_oe(1'b0);
    ovl = 1'b0;
    wait_empty();

    // R7: single-clock overload in the middle of a retry window
    phase = "R7";
    push("R3", 0, 0, 1, (Q - 1) * P + 1, Q * P);
    push("R6", 1, 1, 1, TOFF * P, TOFF * P);
    push("R7", 0, 0, 1, TON * P, TON * P);
    push("R6", 1, 1, 1, TOFF * P, TOFF * P);
    push("R8", 1, 0, 0, TON * P, TON * P);
    start_overload();
    wait_oe(1'b0);
    ovl = 1'b0;
    wait_oe(1'b1);
    repeat (7) @(negedge clk);
    ovl = 1'b1;
    @(negedge clk);
    ovl = 1'b0;
    wait_empty();

    // R9: disable during the off interval, then re-enable
    phase = "R9";
    push("R3", 0, 0, 1, (Q - 1) * P + 1, Q * P);
    start_overload();
    wait_oe(1'b0);
    ovl = 1'b0;
    wait_empty();
    push("R9", 0, 0, 0, 1, 1);
    @(negedge clk);
    mark = cyc;
    chip_en = 1'b0;
    wait_empty();
    push("R9", 1, 0, 0, 1, 1);
    mark = cyc;
    chip_en = 1'b1;
    wait_empty();
    repeat ((TOFF + TON) * P + 10) @(negedge clk);
    direct("R9", {out_en, retry_lim, ovl_flag}, 4);

    if (!fin) begin
      fin = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL %s: watchdog expired, actual running expected done", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule